// File: doc/BRIEF.md
# Cache-Line Preset Tracking Controller

This block keeps a small set of state bits for every line of a DRAM cache that fronts phase-change main memory. Writing a phase-change cell to the crystalline state is slow while writing it to the amorphous state is fast. The block arranges for the slow half of a line's writeback to happen early. The first time a resident line is written, the block asks the memory side to pre-set that line's home location. When the line is later evicted dirty and that early operation has been confirmed, the writeback can take the fast path, which only drives cells to the amorphous state.

One event stream drives the block. Every event names a line slot by set and way, carries a line address and has one of four kinds. An install places a new line in the slot. A write hit marks the slot's line as modified. An evict removes the line from the slot. A completion reports that the memory side has finished pre-setting an address.

The block has two output streams, and both use valid/ready handshakes. The preset stream carries only a line address. The writeback stream carries the line address plus a fast/slow flag. Each output has a single register stage. A payload stays on its output until the consumer accepts it. A full preset stage never stalls the event stream: the block skips the preset and tries again on a later write. A full writeback stage holds back evict events only.

Top module: `pcm_preset_tracker`

## Requirements
- R1: After reset every line slot is invalid, `ps_valid` and `wb_valid` are low, and `ev_ready` is high.
- R2: An accepted install event (code 0) makes the slot valid and records `ev_addr` as its line address. It clears the slot's dirty, preset-initiated and preset-done bits and produces no output.
- R3: An accepted write event (code 1) to a valid slot sets the dirty bit. If the slot's initiated bit is clear and the preset stage is free, the next cycle shows a preset request carrying the slot's stored address, and the initiated bit is set. The stage is free when it is empty, or when it is being accepted in the same cycle.
- R4: A write event to a slot whose initiated bit is already set issues no preset request.
- R5: A write event that arrives while the preset stage holds an unaccepted request issues no request and leaves the initiated bit clear. A later write to the same slot retries the request.
- R6: An accepted completion event (code 3) sets the done bit only when the slot is valid, its initiated bit is set, and `ev_addr` equals the stored address. Any other completion event is ignored.
- R7: An accepted evict event (code 2) on a valid dirty slot loads a writeback with the stored address. `wb_fast` is 1 exactly when the done bit was set, and the slot becomes invalid.
- R8: Evicting a clean or invalid slot produces no writeback, whatever its preset bits hold. The slot is invalid afterwards.
- R9: An output whose valid is high and whose ready is low keeps valid high and its payload unchanged. `ev_ready` is low only for an evict event while the writeback stage is full and not being accepted.
- R10: A write event to an invalid slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted this cycle when valid is also high |
| ev_kind | input | 2 | 0 install, 1 write, 2 evict, 3 completion |
| ev_set | input | log2(SETS) | Set index of the slot |
| ev_way | input | log2(WAYS) | Way index of the slot |
| ev_addr | input | ADDR_W | Line address |
| ps_valid | output | 1 | Preset request present |
| ps_ready | input | 1 | Preset consumer accepts |
| ps_addr | output | ADDR_W | Line address to pre-set |
| wb_valid | output | 1 | Writeback request present |
| wb_ready | input | 1 | Writeback consumer accepts |
| wb_addr | output | ADDR_W | Line address to write back |
| wb_fast | output | 1 | 1 selects the fast write that only drives cells to the amorphous state |

## Verification
The bench builds the block with SETS=4, WAYS=2 and ADDR_W=12, so there are eight slots. Random events therefore hit the same slot often: write-after-install, write repeated on a slot that already started its preset, completion after eviction, and evict of a clean line. Line addresses are drawn from a pool of six values, so completion events regularly carry a wrong address. Ready signals are toggled at random, which fills both output stages and exercises the preset skip and the held-off evict events.

// File: rtl/pcm_pst_pkg.sv
package pcm_pst_pkg;
  typedef enum logic [1:0] {
    EV_INSTALL = 2'd0,
    EV_WRITE   = 2'd1,
    EV_EVICT   = 2'd2,
    EV_DONE    = 2'd3
  } ev_kind_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic pinit;
    logic pdone;
  } line_flags_t;
endpackage

// File: rtl/lpt_meta_table.sv
module lpt_meta_table
  import pcm_pst_pkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int ADDR_W  = 34,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output line_flags_t       rd_flags,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_flags_t       wr_flags,
  input  logic              wr_addr_en,
  input  logic [ADDR_W-1:0] wr_addr
);
  line_flags_t       flags_q [ENTRIES];
  logic [ADDR_W-1:0] addr_q  [ENTRIES];

  // flags need a known value after reset; addresses are only read when valid
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) flags_q[i] <= '0;
    end else if (wr_en) begin
      flags_q[wr_idx] <= wr_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_addr_en) addr_q[wr_idx] <= wr_addr;
  end

  assign rd_flags = flags_q[rd_idx];
  assign rd_addr  = addr_q[rd_idx];
endmodule

// File: rtl/lpt_decide.sv
module lpt_decide
  import pcm_pst_pkg::*;
#(
  parameter int ADDR_W = 34
) (
  input  logic              fire,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] ev_addr,
  input  line_flags_t       cur,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              ps_free,
  output logic              wr_en,
  output line_flags_t       nxt,
  output logic              wr_addr_en,
  output logic              ps_load,
  output logic              wb_load,
  output logic              wb_fast
);
  always_comb begin
    wr_en      = 1'b0;
    nxt        = cur;
    wr_addr_en = 1'b0;
    ps_load    = 1'b0;
    wb_load    = 1'b0;
    wb_fast    = cur.pdone;
    if (fire) begin
      unique case (ev_kind_e'(kind))
        EV_INSTALL: begin
          wr_en      = 1'b1;
          wr_addr_en = 1'b1;
          nxt        = '{valid: 1'b1, dirty: 1'b0, pinit: 1'b0, pdone: 1'b0};
        end
        EV_WRITE: begin
          if (cur.valid) begin
            wr_en     = 1'b1;
            nxt.dirty = 1'b1;
            if (!cur.pinit && ps_free) begin
              ps_load   = 1'b1;
              nxt.pinit = 1'b1;
            end
          end
        end
        EV_EVICT: begin
          wr_en     = 1'b1;
          nxt.valid = 1'b0;
          wb_load   = cur.valid && cur.dirty;
        end
        EV_DONE: begin
          if (cur.valid && cur.pinit && (cur_addr == ev_addr)) begin
            wr_en     = 1'b1;
            nxt.pdone = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lpt_out_slot.sv
module lpt_out_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         free,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign free = !out_valid || out_ready;
endmodule

// File: rtl/pcm_preset_tracker.sv
module pcm_preset_tracker
  import pcm_pst_pkg::*;
#(
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int ADDR_W = 34
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_valid,
  output logic                    ev_ready,
  input  logic [1:0]              ev_kind,
  input  logic [$clog2(SETS)-1:0] ev_set,
  input  logic [$clog2(WAYS)-1:0] ev_way,
  input  logic [ADDR_W-1:0]       ev_addr,
  output logic                    ps_valid,
  input  logic                    ps_ready,
  output logic [ADDR_W-1:0]       ps_addr,
  output logic                    wb_valid,
  input  logic                    wb_ready,
  output logic [ADDR_W-1:0]       wb_addr,
  output logic                    wb_fast
);
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int IDX_W   = SET_W + WAY_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0]  idx;
  line_flags_t       rd_flags;
  line_flags_t       nxt_flags;
  logic [ADDR_W-1:0] rd_addr;
  logic              fire, wr_en, wr_addr_en;
  logic              ps_load, ps_free, wb_load, wb_free, wb_fast_in;

  assign idx      = {ev_set, ev_way};
  assign ev_ready = wb_free || (ev_kind != EV_EVICT);
  assign fire     = ev_valid && ev_ready;

  lpt_meta_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (idx),
    .rd_flags  (rd_flags),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_idx    (idx),
    .wr_flags  (nxt_flags),
    .wr_addr_en(wr_addr_en),
    .wr_addr   (ev_addr)
  );

  lpt_decide #(.ADDR_W(ADDR_W)) i_decide (
    .fire      (fire),
    .kind      (ev_kind),
    .ev_addr   (ev_addr),
    .cur       (rd_flags),
    .cur_addr  (rd_addr),
    .ps_free   (ps_free),
    .wr_en     (wr_en),
    .nxt       (nxt_flags),
    .wr_addr_en(wr_addr_en),
    .ps_load   (ps_load),
    .wb_load   (wb_load),
    .wb_fast   (wb_fast_in)
  );

  lpt_out_slot #(.W(ADDR_W)) i_ps_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ps_load),
    .load_data(rd_addr),
    .free     (ps_free),
    .out_valid(ps_valid),
    .out_ready(ps_ready),
    .out_data (ps_addr)
  );

  lpt_out_slot #(.W(ADDR_W + 1)) i_wb_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wb_load),
    .load_data({wb_fast_in, rd_addr}),
    .free     (wb_free),
    .out_valid(wb_valid),
    .out_ready(wb_ready),
    .out_data ({wb_fast, wb_addr})
  );
endmodule

// File: rtl/pcm_preset_tracker_chk.sv
module pcm_preset_tracker_chk
  import pcm_pst_pkg::*;
#(
  parameter int ADDR_W = 34
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [1:0]        ev_kind,
  input logic              ps_valid,
  input logic              ps_ready,
  input logic [ADDR_W-1:0] ps_addr,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              wb_fast,
  input line_flags_t       rd_flags
);
  assert_ps_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ps_valid && !ps_ready |=> ps_valid && $stable(ps_addr));

  assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_fast));

  assert_ps_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_valid) |-> $past(ev_valid && ev_ready && ev_kind == EV_WRITE));

  assert_wb_from_evict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(ev_valid && ev_ready && ev_kind == EV_EVICT));

  assert_done_after_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && rd_flags.valid |-> !(rd_flags.pdone && !rd_flags.pinit));

  assert_init_implies_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && rd_flags.valid && rd_flags.pinit |-> rd_flags.dirty);
endmodule

bind pcm_preset_tracker pcm_preset_tracker_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ev_valid(ev_valid),
  .ev_ready(ev_ready),
  .ev_kind (ev_kind),
  .ps_valid(ps_valid),
  .ps_ready(ps_ready),
  .ps_addr (ps_addr),
  .wb_valid(wb_valid),
  .wb_ready(wb_ready),
  .wb_addr (wb_addr),
  .wb_fast (wb_fast),
  .rd_flags(rd_flags)
);

// File: tb/test_pcm_preset_tracker.sv
module test_pcm_preset_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int SETS   = 4;
  localparam int WAYS   = 2;
  localparam int ADDR_W = 12;
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int N      = SETS * WAYS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, ps_ready = 1'b0, wb_ready = 1'b0;
  logic [1:0] ev_kind = '0;
  logic [SET_W-1:0] ev_set = '0;
  logic [WAY_W-1:0] ev_way = '0;
  logic [ADDR_W-1:0] ev_addr = '0;
  logic ev_ready, ps_valid, wb_valid, wb_fast;
  logic [ADDR_W-1:0] ps_addr, wb_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pcm_preset_tracker #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W)) i_pcm_preset_tracker (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
    .ev_set(ev_set), .ev_way(ev_way), .ev_addr(ev_addr), .ps_valid(ps_valid),
    .ps_ready(ps_ready), .ps_addr(ps_addr), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_fast(wb_fast)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model, built from the requirements
  bit m_v[N], m_d[N], m_pi[N], m_pd[N];
  logic [ADDR_W-1:0] m_a[N];
  bit e_ps_v = 0, e_wb_v = 0, e_wb_f = 0;
  logic [ADDR_W-1:0] e_ps_a = '0, e_wb_a = '0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] pool(input int i);
    return ADDR_W'(i * 37 + 5);
  endfunction

  task automatic step(input bit v, input int k, input int s, input int w,
                      input logic [ADDR_W-1:0] a, input bit psr, input bit wbr);
    bit exp_rdy, fire, ps_free;
    int idx;
    ev_valid = v; ev_kind = 2'(k); ev_set = SET_W'(s); ev_way = WAY_W'(w);
    ev_addr = a; ps_ready = psr; wb_ready = wbr;
    #1;
    exp_rdy = !(k == 2 && e_wb_v && !wbr);
    check("R9", "ev_ready", ev_ready, exp_rdy);
    @(posedge clk);
    fire = v && exp_rdy;
    ps_free = !e_ps_v || psr;
    if (e_ps_v && psr) e_ps_v = 0;
    if (e_wb_v && wbr) e_wb_v = 0;
    idx = s * WAYS + w;
    if (fire) begin
      case (k)
        0: begin m_v[idx] = 1; m_a[idx] = a; m_d[idx] = 0; m_pi[idx] = 0; m_pd[idx] = 0; end
        1: if (m_v[idx]) begin
             m_d[idx] = 1;
             if (!m_pi[idx] && ps_free) begin e_ps_v = 1; e_ps_a = m_a[idx]; m_pi[idx] = 1; end
           end
        2: begin
             if (m_v[idx] && m_d[idx]) begin e_wb_v = 1; e_wb_a = m_a[idx]; e_wb_f = m_pd[idx]; end
             m_v[idx] = 0;
           end
        default: if (m_v[idx] && m_pi[idx] && m_a[idx] == a) m_pd[idx] = 1;
      endcase
    end
    @(negedge clk);
    check("R3", "ps_valid", ps_valid, e_ps_v);
    if (e_ps_v) check("R3", "ps_addr", ps_addr, e_ps_a);
    check("R7", "wb_valid", wb_valid, e_wb_v);
    if (e_wb_v) begin
      check("R7", "wb_addr", wb_addr, e_wb_a);
      check("R7", "wb_fast", wb_fast, e_wb_f);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1", "ps_valid", ps_valid, 0);
    check("R1", "wb_valid", wb_valid, 0);
    check("R1", "ev_ready", ev_ready, 1);

    // R10: write to an invalid slot, no preset
    step(1, 1, 0, 0, 'h100, 1, 1);
    // R2 then R3: install, first write presets the stored address
    step(1, 0, 0, 0, 'h100, 1, 1);
    step(1, 1, 0, 0, 'h7FF, 1, 1);
    // R4: second write, no new preset
    step(1, 1, 0, 0, 'h100, 1, 1);
    // R6: completion with wrong address ignored, evict is slow
    step(1, 3, 0, 0, 'h101, 1, 1);
    step(1, 2, 0, 0, 'h000, 1, 1);
    // R6 and R7: matching completion gives a fast writeback
    step(1, 0, 0, 0, 'h222, 1, 1);
    step(1, 1, 0, 0, 'h222, 1, 1);
    step(1, 3, 0, 0, 'h222, 1, 1);
    step(1, 2, 0, 0, 'h222, 1, 1);
    // R6: completion after eviction ignored
    step(1, 0, 1, 0, 'h333, 1, 1);
    step(1, 1, 1, 0, 'h333, 1, 1);
    step(1, 2, 1, 0, 'h333, 1, 1);
    step(1, 3, 1, 0, 'h333, 1, 1);
    // R5: preset stage held, write skips, later write retries
    step(1, 0, 2, 0, 'h044, 0, 1);
    step(1, 0, 2, 1, 'h055, 0, 1);
    step(1, 1, 2, 0, 'h044, 0, 1);
    step(1, 1, 2, 1, 'h055, 0, 1);
    step(0, 0, 0, 0, 'h000, 1, 1);
    step(1, 1, 2, 1, 'h055, 1, 1);
    // R8: clean evict with no writeback
    step(1, 0, 3, 0, 'h066, 1, 1);
    step(1, 2, 3, 0, 'h066, 1, 1);
    // R9: writeback stage full holds back the next evict
    step(1, 2, 2, 0, 'h000, 1, 0);
    step(1, 2, 2, 1, 'h000, 1, 0);
    step(1, 2, 2, 1, 'h000, 1, 1);

    for (int i = 0; i < 4000; i++) begin
      int r, k;
      r = int'($urandom_range(99));
      k = (r < 30) ? 0 : (r < 60) ? 1 : (r < 80) ? 2 : 3;
      step($urandom_range(99) < 85, k, int'($urandom_range(SETS - 1)),
           int'($urandom_range(WAYS - 1)), pool(int'($urandom_range(5))),
           $urandom_range(99) < 65, $urandom_range(99) < 65);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule